// File: doc/BRIEF.md
# Carrier-Cycle Interval Interrupt Timer

This block paces an infrared remote-control transmitter that runs in hardware-timed mode. Firmware writes a 4-bit period count into a select register. The block then counts periods of the carrier waveform and raises an interrupt when the programmed number of periods has passed. Firmware uses that interrupt to load the next data bit and rearm the timer. Each count fires once only, so firmware writes the select register again for every bit it transmits.

The block has three small registers on a simple synchronous bus: the period-select register, an interrupt enable mask, and an event flag that clears when it is read. Two remote-enable inputs decide whether the timer may run. When both are low, the timer goes idle and the select register returns to its all-ones value. The carrier is sampled into the system clock domain, and its falling edges mark the period boundaries.

Top module: `carrier_interval_timer`

## Requirements
- R1: A select code n, written to bus address 0 in bits [3:0], makes the count last n+1 carrier periods: code 0 gives 1 period and code 15 gives 16 periods.
- R2: A write to address 0 while either enable input is 1 loads the code and arms a new count. Either enable bit alone is enough.
- R3: Counting starts at the first carrier falling edge after the write. A period ends at each later falling edge, so the flag sets on falling edge n+2 after the write.
- R4: When the count completes, the flag sets even if the interrupt is masked. `irq_o` is 1 exactly when the flag and the mask are both 1.
- R5: Reading address 0 returns 4'b1111 after reset. Whenever both enable inputs are 0, the select register is forced to 4'b1111 and any pending count is abandoned. A write to address 0 made while both enables are 0 has no effect.
- R6: The mask is bit 0 of address 1. It resets to 0, writing 1 or 0 sets or clears it, and reads return its value.
- R7: The flag is bit 0 of address 2 and resets to 0. A read of address 2 returns the flag and then clears it. Writes to address 2 have no effect.
- R8: A completed count does not repeat: the flag stays 0 on later carrier periods until the select register is written again.
- R9: If a flag-clearing read happens in the same cycle that a count completes, the flag ends up 1.
- R10: Writing address 0 while a count is running drops that count and starts a new one under R3.
- R11: A read of address 3 returns 0, and all unused upper read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_in | input | 1 | Carrier waveform, asynchronous to nothing in particular but slower than clk |
| ena_a | input | 1 | First remote-enable bit |
| ena_b | input | 1 | Second remote-enable bit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears the flag on address 2) |
| bus_addr | input | 2 | Register address: 0 select, 1 mask, 2 flag |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check that the select register is forced to all ones while the block is disabled. They also check that a completing count always leaves the flag set, even against a clearing read in the same cycle. A set flag may drop only after a read, and the period counter never passes the programmed code. Only the bench scenarios can show the end-to-end period arithmetic: the flag appears on exactly falling edge n+2 for every one of the sixteen codes, under both mask settings. The bench scenarios also cover one-shot behaviour, restarting a count mid-way and the writes that have no effect, all observed through bus reads and the interrupt pin.

// File: rtl/carrier_interval_timer.sv
module carrier_interval_timer #(
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_in,
  input  logic              ena_a,
  input  logic              ena_b,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(2);
  localparam logic [SEL_W-1:0]  SEL_IDLE = '1;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_COUNT} st_t;

  st_t              st_q;
  logic [SEL_W-1:0] sel_q, cnt_q;
  logic             car_s, car_d, mask_q, flag_q;

  wire en      = ena_a | ena_b;
  wire fall    = car_d & ~car_s;
  wire sel_wr  = bus_wr & (bus_addr == A_SEL);
  wire msk_wr  = bus_wr & (bus_addr == A_MSK);
  wire flg_rd  = bus_rd & (bus_addr == A_FLG);
  wire done    = en & ~sel_wr & fall & (st_q == S_COUNT) & (cnt_q == sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_s  <= 1'b0;
      car_d  <= 1'b0;
      sel_q  <= SEL_IDLE;
      cnt_q  <= '0;
      st_q   <= S_IDLE;
      mask_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      car_s <= carrier_in;
      car_d <= car_s;
      if (!en) begin
        sel_q <= SEL_IDLE;
        cnt_q <= '0;
        st_q  <= S_IDLE;
      end else if (sel_wr) begin
        sel_q <= bus_wdata[SEL_W-1:0];
        cnt_q <= '0;
        st_q  <= S_ARMED;
      end else if (fall) begin
        case (st_q)
          S_ARMED: begin
            st_q  <= S_COUNT;
            cnt_q <= '0;
          end
          S_COUNT: begin
            if (cnt_q == sel_q) st_q <= S_IDLE;
            else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= S_IDLE;
        endcase
      end
      if (msk_wr) mask_q <= bus_wdata[0];
      flag_q <= done | (flag_q & ~flg_rd);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SEL:   bus_rdata[SEL_W-1:0] = sel_q;
      A_MSK:   bus_rdata[0] = mask_q;
      A_FLG:   bus_rdata[0] = flag_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o = flag_q & mask_q;

  assert_sel_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ena_a | ena_b) |=> (sel_q == SEL_IDLE) && (st_q == S_IDLE));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);

  assert_flag_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_rd && !done) |=> !flag_q);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flg_rd) |=> flag_q);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_COUNT) |-> (cnt_q <= sel_q));

  assert_irq_needs_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (mask_q && flag_q));

endmodule

// File: tb/sim_carrier_interval_timer.sv
module sim_carrier_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, car = 1'b1, ena_a = 1'b0, ena_b = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0, bus_rdata;
  logic irq_o;
  int checks = 0, errors = 0;
  logic [3:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  carrier_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .carrier_in(car), .ena_a(ena_a), .ena_b(ena_b),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic period();
    @(negedge clk); car = 1'b0;
    repeat (3) @(negedge clk);
    car = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd0, v); chk(v == 4'hF, "R5 reset select", v, 15);
    rd(2'd1, v); chk(v == 4'h0, "R6 reset mask", v, 0);
    rd(2'd2, v); chk(v == 4'h0, "R7 reset flag", v, 0);
    chk(irq_o == 1'b0, "R4 reset irq", irq_o, 0);
    rd(2'd3, v); chk(v == 4'h0, "R11 unused address", v, 0);

    ena_a = 1'b1;
    for (int n = 0; n < 16; n++) begin
      wr(2'd1, {3'b0, n[0]});
      rd(2'd1, v); chk(v == {3'b0, n[0]}, "R6 mask readback", v, n[0]);
      wr(2'd0, 4'(n));
      rd(2'd0, v); chk(v == 4'(n), "R2 select readback", v, n);
      for (int p = 1; p <= n + 1; p++) begin
        period();
        chk(u0.irq_o == 1'b0 && irq_o == 1'b0, "R3 no early irq", irq_o, 0);
      end
      period();
      chk(irq_o == n[0], "R4 irq follows mask", irq_o, n[0]);
      rd(2'd2, v); chk(v == 4'h1, "R1 flag after n+2 edges", v, 1);
      rd(2'd2, v); chk(v == 4'h0, "R7 flag cleared by read", v, 0);
      chk(irq_o == 1'b0, "R4 irq drops with flag", irq_o, 0);
    end

    repeat (4) period();
    rd(2'd2, v); chk(v == 4'h0, "R8 one-shot", v, 0);

    wr(2'd0, 4'd0); period(); period();
    wr(2'd2, 4'h0);
    rd(2'd2, v); chk(v == 4'h1, "R7 write to flag ignored (clear)", v, 1);
    wr(2'd2, 4'hF);
    rd(2'd2, v); chk(v == 4'h0, "R7 write to flag ignored (set)", v, 0);

    wr(2'd0, 4'd3); period(); period();
    wr(2'd0, 4'd1);
    period(); period();
    rd(2'd2, v); chk(v == 4'h0, "R10 restart no early flag", v, 0);
    period();
    rd(2'd2, v); chk(v == 4'h1, "R10 restart completes", v, 1);

    wr(2'd0, 4'd0); period();
    @(negedge clk); car = 1'b0;
    @(negedge clk); bus_rd = 1'b1; bus_addr = 2'd2;
    @(negedge clk); bus_rd = 1'b0;
    repeat (2) @(negedge clk); car = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk(v == 4'h1, "R9 set wins over clear", v, 1);

    wr(2'd0, 4'd2); period();
    ena_a = 1'b0;
    @(negedge clk);
    rd(2'd0, v); chk(v == 4'hF, "R5 disable forces all ones", v, 15);
    wr(2'd0, 4'd0);
    rd(2'd0, v); chk(v == 4'hF, "R5 write while disabled ignored", v, 15);
    repeat (6) period();
    rd(2'd2, v); chk(v == 4'h0, "R5 count abandoned", v, 0);

    ena_b = 1'b1;
    wr(2'd1, 4'h1);
    wr(2'd0, 4'd1);
    period(); period();
    chk(irq_o == 1'b0, "R2 enable b not yet", irq_o, 0);
    period();
    chk(irq_o == 1'b1, "R2 enable b alone counts", irq_o, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule